// File: doc/BRIEF.md
# RAID-6 dual parity (P/Q) syndrome generator

The block computes the two check bytes of a RAID-6 stripe from a stream of data bytes. A job is opened with a one-cycle start pulse that carries the total disk count N (data disks plus the two check slots) and the number of stripe offsets. For each offset the caller sends one beat per data disk on a valid/ready stream. The beats go from the highest data disk, N-3, down to disk 0. Each beat carries LANES independent byte lanes, one byte per lane.

P is the XOR parity of the data bytes. Q is the Reed-Solomon syndrome sum of g^i·D_i over GF(2^8), with generator g = 2 and field polynomial x^8+x^4+x^3+x^2+1. Q is evaluated by Horner's rule: the running value is doubled in the field and the next lower disk's byte is XORed in. After the disk-0 beat of an offset, the block presents P and Q on a registered output with its own valid/ready pair. It then starts the next offset from cleared accumulators.

Top module: `pq_syndrome_gen`

## Requirements
- R1: After reset, out_valid, in_ready, busy and cfg_err are all 0.
- R2: A start seen while idle with cfg_disks below 4, or with cfg_beats equal to 0, sets cfg_err to 1. In that case busy stays 0, in_ready stays 0 and no output is produced. Any later start accepted while idle recomputes cfg_err, which is 0 for a legal configuration.
- R3: For every offset and every lane k, the P byte in bits 8k+7:8k of out_p equals the XOR of lane k of all N-2 data beats of that offset.
- R4: For every offset and every lane k, the Q byte in bits 8k+7:8k of out_q equals the sum over data disks i of 2^i·D_i in GF(2^8) with polynomial 0x11d. Each field doubling is a left shift followed by an XOR with 0x1d when the byte's top bit was set.
- R5: Each offset takes exactly N-2 accepted beats, and the first of them belongs to disk N-3. out_valid is 1 in the cycle after the disk-0 beat is accepted.
- R6: An offset's result does not depend on the data of any earlier offset. An offset whose data are all zero yields P = Q = 0.
- R7: While out_valid is 1 and out_ready is 0, out_p, out_q and out_valid hold their values and in_ready is 0.
- R8: A job delivers exactly cfg_beats results. busy then falls once the last result has been taken, and in_ready is 0 from that point on.
- R9: A start pulse while busy is 1 is ignored. The running job completes with its original disk count and offset count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a job when idle |
| cfg_disks | input | DISK_W | Total disk count N, check slots included |
| cfg_beats | input | BEAT_W | Number of stripe offsets in the job |
| in_valid | input | 1 | Data beat present |
| in_ready | output | 1 | Data beat accepted this cycle when in_valid is 1 |
| in_data | input | LANES*8 | One byte per lane, lane k in bits 8k+7:8k |
| out_valid | output | 1 | P/Q result present |
| out_ready | input | 1 | Consumer takes the result |
| out_p | output | LANES*8 | XOR parity, per lane |
| out_q | output | LANES*8 | GF(2^8) syndrome, per lane |
| busy | output | 1 | Job running or result pending |
| cfg_err | output | 1 | Last start had an illegal configuration |

## Verification
The bench builds the block with LANES=4, DISK_W=5 and BEAT_W=4. Four lanes with differing data show whether the lanes stay independent. A 5-bit disk count allows stripes of 20 disks, so the Q weights reach 2^17 and pass the first field reductions several times over. The bench also runs the smallest legal stripe of two data disks. A 4-bit offset count keeps the jobs short, so that stalling and free-running consumers and a start pulse during a job all fit in one run.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam logic [7:0] GF_RED = 8'h1d;
  localparam int         MIN_DISKS = 4;

  // Field doubling: sign of the byte picks the reduction mask.
  function automatic logic [7:0] gf_dbl(input logic [7:0] b);
    logic [7:0] msk;
    msk = ($signed(b) < 0) ? 8'hff : 8'h00;
    return {b[6:0], 1'b0} ^ (msk & GF_RED);
  endfunction
endpackage

// File: rtl/pq_lane.sv
module pq_lane
  import pq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       clr,
  input  logic [7:0] din,
  output logic [7:0] nxt_p,
  output logic [7:0] nxt_q
);
  logic [7:0] acc_p;
  logic [7:0] acc_q;

  assign nxt_p = acc_p ^ din;
  assign nxt_q = gf_dbl(acc_q) ^ din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_p <= '0;
      acc_q <= '0;
    end else if (take) begin
      acc_p <= clr ? 8'h00 : nxt_p;
      acc_q <= clr ? 8'h00 : nxt_q;
    end
  end

  // R6: after the closing beat of an offset nothing is carried over
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && clr |=> acc_p == 8'h00 && acc_q == 8'h00);
endmodule

// File: rtl/pq_seq.sv
module pq_seq
  import pq_pkg::*;
#(
  parameter int DISK_W = 6,
  parameter int BEAT_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DISK_W-1:0] cfg_disks,
  input  logic [BEAT_W-1:0] cfg_beats,
  input  logic              fire,
  input  logic              out_valid,
  output logic              run,
  output logic              last_disk,
  output logic              busy,
  output logic              cfg_err
);
  logic [DISK_W-1:0] top_idx;
  logic [DISK_W-1:0] disk_idx;
  logic [BEAT_W-1:0] beats_left;
  logic              take_start;
  logic              bad_cfg;

  assign busy       = run || out_valid;
  assign take_start = start && !busy;
  assign bad_cfg    = (cfg_disks < DISK_W'(MIN_DISKS)) || (cfg_beats == '0);
  assign last_disk  = (disk_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      cfg_err    <= 1'b0;
      top_idx    <= '0;
      disk_idx   <= '0;
      beats_left <= '0;
    end else if (take_start) begin
      cfg_err <= bad_cfg;
      if (!bad_cfg) begin
        run        <= 1'b1;
        top_idx    <= cfg_disks - DISK_W'(3);
        disk_idx   <= cfg_disks - DISK_W'(3);
        beats_left <= cfg_beats;
      end
    end else if (fire) begin
      if (last_disk) begin
        disk_idx   <= top_idx;
        beats_left <= beats_left - BEAT_W'(1);
        if (beats_left == BEAT_W'(1)) run <= 1'b0;
      end else begin
        disk_idx <= disk_idx - DISK_W'(1);
      end
    end
  end

  // R5: the disk index never leaves the range of data disks
  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> disk_idx <= top_idx);
  // R9: a start during a job leaves the job configuration untouched
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> $stable(top_idx) && $stable(cfg_err));
  // R2: a rejected configuration never runs
  p_err_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !run);
endmodule

// File: rtl/pq_syndrome_gen.sv
module pq_syndrome_gen #(
  parameter int LANES  = 8,
  parameter int DISK_W = 6,
  parameter int BEAT_W = 8
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [DISK_W-1:0]   cfg_disks,
  input  logic [BEAT_W-1:0]   cfg_beats,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*8-1:0]  in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*8-1:0]  out_p,
  output logic [LANES*8-1:0]  out_q,
  output logic                busy,
  output logic                cfg_err
);
  localparam int BUS_W = LANES * 8;

  logic             run;
  logic             last_disk;
  logic             fire;
  logic             emit;
  logic [BUS_W-1:0] sum_p;
  logic [BUS_W-1:0] sum_q;

  assign in_ready = run && (!out_valid || out_ready);
  assign fire     = in_valid && in_ready;
  assign emit     = fire && last_disk;

  pq_seq #(.DISK_W(DISK_W), .BEAT_W(BEAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_disks(cfg_disks),
    .cfg_beats(cfg_beats), .fire(fire), .out_valid(out_valid),
    .run(run), .last_disk(last_disk), .busy(busy), .cfg_err(cfg_err)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pq_lane u_lane (
      .clk(clk), .rst_n(rst_n), .take(fire), .clr(last_disk),
      .din(in_data[8*k +: 8]),
      .nxt_p(sum_p[8*k +: 8]), .nxt_q(sum_q[8*k +: 8])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_p     <= '0;
      out_q     <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_p     <= sum_p;
      out_q     <= sum_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: a stalled result is held
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_p) && $stable(out_q));
  // R7: no beat is taken while the result register is blocked
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R5: the disk-0 beat produces a result in the next cycle
  p_emit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && last_disk |=> out_valid);
endmodule

// File: tb/pq_syndrome_gen_test.sv
`timescale 1ns/1ps
module pq_syndrome_gen_test;
  localparam int LANES = 4;
  localparam int DW    = 5;
  localparam int BW    = 4;
  localparam int BUS   = LANES * 8;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           start = 0;
  logic [DW-1:0]  cfg_disks = '0;
  logic [BW-1:0]  cfg_beats = '0;
  logic           in_valid = 0;
  logic           in_ready;
  logic [BUS-1:0] in_data = '0;
  logic           out_valid;
  logic           out_ready = 1;
  logic [BUS-1:0] out_p, out_q;
  logic           busy, cfg_err;

  pq_syndrome_gen #(.LANES(LANES), .DISK_W(DW), .BEAT_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_disks(cfg_disks),
    .cfg_beats(cfg_beats), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_p(out_p), .out_q(out_q), .busy(busy), .cfg_err(cfg_err)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, rx = 0, scnt = 0;
  bit stall = 0;
  string tag_p = "R3", tag_q = "R4";
  int gexp[0:254];
  int glog[0:255];
  logic [BUS-1:0] qp[$], qq[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int gmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 255];
  endfunction

  function automatic logic [7:0] pat(input int seed, input int off, input int dk, input int ln);
    if (seed == 4 && off == 1) return 8'h00;
    if (seed == 3) return ((dk % 2) != 0) ? (8'hff ^ 8'(ln)) : (8'h80 | 8'(ln));
    return 8'(((off * 37 + dk * 101 + ln * 59 + seed * 13 + 7) * 29) & 255);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog R8 actual=%0d expected<=100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    #2;
    scnt++;
    out_ready = stall ? ((scnt % 3) == 2) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (qp.size() == 0) begin
        chk(0, "R8 unexpected result", 64'(out_p), 64'h0);
      end else begin
        chk(out_p == qp[0], tag_p, 64'(out_p), 64'(qp[0]));
        chk(out_q == qq[0], tag_q, 64'(out_q), 64'(qq[0]));
        if (!out_ready) chk(in_ready == 0, "R7 in_ready during stall", 64'(in_ready), 64'h0);
        if (out_ready) begin
          void'(qp.pop_front());
          void'(qq.pop_front());
          rx++;
        end
      end
    end
  end

  task automatic run_job(input int disks, input int beats, input int seed, input bit inject);
    int nd = disks - 2;
    for (int o = 0; o < beats; o++) begin
      logic [BUS-1:0] ep = '0, eq = '0;
      for (int l = 0; l < LANES; l++) begin
        int p = 0, q = 0;
        for (int d = 0; d < nd; d++) begin
          p = p ^ int'(pat(seed, o, d, l));
          q = q ^ gmul(gexp[d], int'(pat(seed, o, d, l)));
        end
        ep[8*l +: 8] = 8'(p);
        eq[8*l +: 8] = 8'(q);
      end
      qp.push_back(ep);
      qq.push_back(eq);
    end
    rx = 0;
    @(negedge clk);
    cfg_disks = DW'(disks);
    cfg_beats = BW'(beats);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1 && cfg_err == 0, "R2 legal start runs", 64'({busy, cfg_err}), 64'h2);
    for (int o = 0; o < beats; o++) begin
      for (int d = nd - 1; d >= 0; d--) begin
        bit inj = inject && o == 0 && d == 3;
        in_valid = 1;
        for (int l = 0; l < LANES; l++) in_data[8*l +: 8] = pat(seed, o, d, l);
        if (inj) begin
          start = 1;
          cfg_disks = DW'(5);
          cfg_beats = BW'(1);
        end
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        start = 0;
        if (inj) chk(busy == 1 && cfg_err == 0, "R9 start ignored while busy", 64'({busy, cfg_err}), 64'h2);
        if (d == 0) chk(out_valid == 1, "R5 result after disk 0", 64'(out_valid), 64'h1);
      end
    end
    in_valid = 0;
    while (qp.size() != 0 || busy) @(negedge clk);
    chk(rx == beats, "R8 result count", 64'(rx), 64'(beats));
    chk(busy == 0 && in_ready == 0, "R8 idle after job", 64'({busy, in_ready}), 64'h0);
  endtask

  task automatic bad_start(input int disks, input int beats);
    @(negedge clk);
    cfg_disks = DW'(disks);
    cfg_beats = BW'(beats);
    start = 1;
    in_valid = 1;
    @(negedge clk);
    start = 0;
    chk(cfg_err == 1, "R2 cfg_err", 64'(cfg_err), 64'h1);
    for (int i = 0; i < 5; i++) begin
      chk(busy == 0 && in_ready == 0 && out_valid == 0, "R2 no activity",
          64'({busy, in_ready, out_valid}), 64'h0);
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  initial begin
    int v = 1;
    for (int i = 0; i < 255; i++) begin
      gexp[i] = v;
      glog[v] = i;
      v = v << 1;
      if (v > 255) v = v ^ 'h11d;
    end
    glog[0] = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && in_ready == 0 && busy == 0 && cfg_err == 0, "R1 reset state",
        64'({out_valid, in_ready, busy, cfg_err}), 64'h0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && in_ready == 0 && busy == 0 && cfg_err == 0, "R1 after release",
        64'({out_valid, in_ready, busy, cfg_err}), 64'h0);

    bad_start(3, 2);
    bad_start(2, 1);
    bad_start(4, 0);

    stall = 0;
    run_job(4, 3, 1, 0);
    chk(cfg_err == 0, "R2 error cleared by legal start", 64'(cfg_err), 64'h0);
    stall = 1;
    run_job(10, 4, 2, 0);
    stall = 0;
    run_job(20, 2, 3, 1);
    tag_p = "R6 P"; tag_q = "R6 Q";
    stall = 1;
    run_job(6, 3, 4, 0);
    tag_p = "R3"; tag_q = "R4";
    stall = 0;
    run_job(5, 15, 5, 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule